// File: doc/BRIEF.md
# Input Selection and Gating Stage

This block is the front end of a configurable logic cell. Four data multiplexers each pick one bit from a 32-bit input bus, using a 5-bit select per multiplexer. Each selected bit is offered in both its true and its complemented form. Four gates then each OR together any chosen mix of those eight terms. A per-gate polarity bit can invert each gate result before it leaves the block.

The selects, the four gate enable bytes and the four polarity bits are held in configuration registers. These registers capture the configuration ports on a clock edge when the load strobe is high, and they clear to zero on reset. From the input bus to the gate outputs the path is purely combinational. A downstream logic-function stage consumes the four gate outputs.

Top module: `lc_input_gating`

## Requirements
- R1: After reset every select, enable and polarity register is 0, so all four gate outputs are 0 for any input bus value.
- R2: Data multiplexer k (k = 0..3) delivers bus bit `in_bus[sel_k]`, where `sel_k` is the 5-bit field `sel_flat[5k+4:5k]` and holds a value from 0 to 31.
- R3: In gate g's enable byte `gate_en_flat[8g+7:8g]`, bit 2k+1 enables the true value of data k and bit 2k enables its complement. Bit 7 is the true value of the fourth data signal and bit 0 is the complement of the first.
- R4: Before polarity, a gate's result is the OR of all its enabled terms.
- R5: Polarity bit `pol[g]` inverts the result of gate g when set, giving `gate_out[g]`. Bit 0 belongs to the first gate.
- R6: A gate with no enable bits set gives 0 before polarity, so its output is a constant 1 when its polarity bit is set.
- R7: A gate that enables both the true and complemented term of the same data signal gives a constant 1 before polarity.
- R8: The configuration registers load all configuration ports on a rising clock edge when `cfg_we` is 1. While `cfg_we` is 0, changes on the configuration ports have no effect on the outputs.
- R9: The outputs follow `in_bus` with no clock edge in between; there is no register on the data path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous active-high reset of the configuration |
| cfg_we | input | 1 | Load strobe for all configuration registers |
| sel_flat | input | 20 | Four 5-bit multiplexer selects, multiplexer k at bits 5k+4:5k |
| gate_en_flat | input | 32 | Four gate enable bytes, gate g at bits 8g+7:8g |
| pol | input | 4 | Per-gate output inversion, gate g at bit g |
| in_bus | input | 32 | Input signal bus |
| gate_out | output | 4 | Gate results after polarity |

## Verification
A wrong configuration register shows up directly at the ports. A select off by one routes the wrong bus bit, an enable bit landing in the wrong position swaps a true term for a complemented one, and a wrong polarity bit flips a gate. Because the data path is combinational, each of these faults appears at `gate_out` as soon as `in_bus` moves after the configuration load edge. A configuration that loads while `cfg_we` is low shows up on the first edge after the ignored write.

// File: rtl/lc_gating_pkg.sv
package lc_gating_pkg;

    localparam int BUS_W    = 32;
    localparam int NUM_DATA = 4;
    localparam int NUM_GATE = 4;
    localparam int SEL_W    = $clog2(BUS_W);
    localparam int EN_W     = 2 * NUM_DATA;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [EN_W-1:0]  gate_en_t;

    typedef struct packed {
        gate_en_t en;
        logic     inv;
    } gate_cfg_t;

    // Term vector for one gate: bit 2k+1 true of data k, bit 2k complement
    function automatic gate_en_t expand_terms(input logic [NUM_DATA-1:0] d);
        gate_en_t t;
        for (int k = 0; k < NUM_DATA; k++) begin
            t[2*k+1] = d[k];
            t[2*k]   = ~d[k];
        end
        return t;
    endfunction

endpackage

// File: rtl/lc_cfg_regs.sv
module lc_cfg_regs
    import lc_gating_pkg::*;
#(
    parameter int N_SEL  = NUM_DATA,
    parameter int N_GATE = NUM_GATE
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [N_SEL*SEL_W-1:0]  sel_in,
    input  logic [N_GATE*EN_W-1:0]  en_in,
    input  logic [N_GATE-1:0]       pol_in,
    output sel_t                    sel_q [N_SEL],
    output gate_cfg_t               gate_q [N_GATE]
);

    for (genvar k = 0; k < N_SEL; k++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst)       sel_q[k] <= '0;
            else if (load) sel_q[k] <= sel_in[k*SEL_W +: SEL_W];
        end

        AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
            load |=> sel_q[k] == $past(sel_in[k*SEL_W +: SEL_W])); // R8
        AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
            !load |=> $stable(sel_q[k])); // R8
    end

    for (genvar g = 0; g < N_GATE; g++) begin : g_gate
        always_ff @(posedge clk) begin
            if (rst) begin
                gate_q[g] <= '0;
            end else if (load) begin
                gate_q[g].en  <= en_in[g*EN_W +: EN_W];
                gate_q[g].inv <= pol_in[g];
            end
        end

        AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
            !load |=> $stable(gate_q[g])); // R8
        AST_GATE_CLEAR: assert property (@(posedge clk)
            rst |=> gate_q[g] == '0); // R1
    end

endmodule

// File: rtl/lc_data_mux.sv
module lc_data_mux
    import lc_gating_pkg::*;
#(
    parameter int W  = BUS_W,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  bus,
    input  logic [SW-1:0] sel,
    output logic          d
);

    always_comb begin
        d = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (sel == SW'(i)) d = bus[i];
        end
    end

endmodule

// File: rtl/lc_gate_term.sv
module lc_gate_term
    import lc_gating_pkg::*;
(
    input  logic [NUM_DATA-1:0] d,
    input  gate_cfg_t           cfg,
    output logic                raw,
    output logic                q
);

    gate_en_t terms;

    always_comb begin
        terms = expand_terms(d);
        raw   = |(terms & cfg.en);
        q     = raw ^ cfg.inv;
    end

    always_comb begin
        if (!$isunknown({d, cfg})) begin
            if (cfg.en == '0) begin
                AST_EMPTY_ZERO: assert (raw == 1'b0); // R6
            end
            for (int k = 0; k < NUM_DATA; k++) begin
                if (cfg.en[2*k+1] && cfg.en[2*k]) begin
                    AST_PAIR_ONE: assert (raw == 1'b1); // R7
                end
            end
            AST_POL_FLIP: assert (q == (cfg.inv ? ~raw : raw)); // R5
        end
    end

endmodule

// File: rtl/lc_input_gating.sv
module lc_input_gating
    import lc_gating_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cfg_we,
    input  logic [NUM_DATA*SEL_W-1:0]   sel_flat,
    input  logic [NUM_GATE*EN_W-1:0]    gate_en_flat,
    input  logic [NUM_GATE-1:0]         pol,
    input  logic [BUS_W-1:0]            in_bus,
    output logic [NUM_GATE-1:0]         gate_out
);

    sel_t                 sel_q  [NUM_DATA];
    gate_cfg_t            gate_q [NUM_GATE];
    logic [NUM_DATA-1:0]  data_sel;
    logic [NUM_GATE-1:0]  gate_raw;

    lc_cfg_regs #(.N_SEL(NUM_DATA), .N_GATE(NUM_GATE)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (cfg_we),
        .sel_in (sel_flat),
        .en_in  (gate_en_flat),
        .pol_in (pol),
        .sel_q  (sel_q),
        .gate_q (gate_q)
    );

    for (genvar k = 0; k < NUM_DATA; k++) begin : g_mux
        lc_data_mux #(.W(BUS_W), .SW(SEL_W)) u_mux (
            .bus (in_bus),
            .sel (sel_q[k]),
            .d   (data_sel[k])
        );
    end

    for (genvar g = 0; g < NUM_GATE; g++) begin : g_gate
        lc_gate_term u_gate (
            .d   (data_sel),
            .cfg (gate_q[g]),
            .raw (gate_raw[g]),
            .q   (gate_out[g])
        );
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> gate_out == '0); // R1

endmodule

// File: tb/lc_input_gating_bench.sv
module lc_input_gating_bench;
    import lc_gating_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [19:0] sel_flat = '0;
    logic [31:0] gate_en_flat = '0;
    logic [3:0]  pol = '0;
    logic [31:0] in_bus = '0;
    logic [3:0]  gate_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lc_input_gating u_lc_input_gating (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .sel_flat(sel_flat),
        .gate_en_flat(gate_en_flat), .pol(pol), .in_bus(in_bus),
        .gate_out(gate_out)
    );

    // Reference: computed from the requirement text
    function automatic logic [3:0] model(input logic [31:0] b, input logic [19:0] s,
                                         input logic [31:0] e, input logic [3:0] p);
        logic [3:0] res;
        logic [3:0] d;
        for (int k = 0; k < 4; k++) d[k] = (b >> s[5*k +: 5]) & 1;
        for (int g = 0; g < 4; g++) begin
            logic acc = 1'b0;
            for (int k = 0; k < 4; k++) begin
                if (e[8*g + 2*k + 1] && d[k])  acc = 1'b1;
                if (e[8*g + 2*k] && !d[k])     acc = 1'b1;
            end
            res[g] = acc ^ p[g];
        end
        return res;
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        checks++;
        if (gate_out !== exp) begin
            errors++;
            $display("FAIL %s: gate_out=%b expected=%b (bus=%h sel=%h en=%h pol=%b)",
                     req, gate_out, exp, in_bus, sel_flat, gate_en_flat, pol);
        end
    endtask

    task automatic load_cfg(input logic [19:0] s, input logic [31:0] e, input logic [3:0] p);
        @(negedge clk);
        sel_flat = s; gate_en_flat = e; pol = p; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [19:0] s_cfg;
        logic [31:0] e_cfg;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, sweep bus patterns
        for (int i = 0; i < 32; i++) begin
            in_bus = 32'h1 << i; #1;
            check("R1", 4'b0000);
            in_bus = ~in_bus; #1;
            check("R1", 4'b0000);
        end

        // R2/R3: every select value on every multiplexer, true term only
        for (int k = 0; k < 4; k++) begin
            for (int s = 0; s < 32; s++) begin
                s_cfg = '0;
                s_cfg[5*k +: 5] = 5'(s);
                e_cfg = '0;
                e_cfg[8*k + 2*k + 1] = 1'b1;
                load_cfg(s_cfg, e_cfg, 4'b0000);
                in_bus = 32'h1 << s; #1;
                check("R2", 4'b1 << k);
                in_bus = ~(32'h1 << s); #1;
                check("R2", 4'b0000);
                // complement term only (R3 bit 2k)
                e_cfg = '0;
                e_cfg[8*k + 2*k] = 1'b1;
                load_cfg(s_cfg, e_cfg, 4'b0000);
                #1;
                check("R3", 4'b1 << k);
            end
        end

        // R4/R5/R6/R7: all 256 enable bytes, varying polarity and bus
        lfsr = 32'hACE1_2345;
        s_cfg = {5'd30, 5'd17, 5'd8, 5'd3};
        for (int e = 0; e < 256; e++) begin
            e_cfg = {8'(e), 8'(e ^ 8'h5A), 8'(255 - e), 8'(e)};
            load_cfg(s_cfg, e_cfg, 4'(e));
            for (int r = 0; r < 4; r++) begin
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                in_bus = lfsr; #1;
                check("R4", model(in_bus, s_cfg, e_cfg, 4'(e)));
            end
        end

        // R6: empty gates with polarity set give 1
        load_cfg(20'h12345, 32'h0, 4'b1010);
        in_bus = 32'hFFFF_FFFF; #1;
        check("R6", 4'b1010);
        in_bus = 32'h0; #1;
        check("R6", 4'b1010);

        // R7: T and N of same signal in each gate give constant 1
        load_cfg(20'h0F0F0, 32'hC030_0C03, 4'b0100);
        for (int i = 0; i < 8; i++) begin
            in_bus = 32'h1111_1111 * i; #1;
            check("R7", 4'b1011);
        end

        // R8: port changes with cfg_we low are ignored
        s_cfg = {5'd0, 5'd0, 5'd0, 5'd5};
        e_cfg = 32'h0000_0002;
        load_cfg(s_cfg, e_cfg, 4'b0000);
        in_bus = 32'h20; #1;
        check("R8", 4'b0001);
        @(negedge clk);
        sel_flat = '0; gate_en_flat = 32'hFFFF_FFFF; pol = 4'hF;
        @(negedge clk); @(negedge clk);
        check("R8", 4'b0001);
        in_bus = 32'h0; #1;
        check("R8", 4'b0000);

        // R9: bus change seen between clock edges
        @(posedge clk); #1;
        in_bus = 32'h20; #0.5;
        check("R9", 4'b0001);
        in_bus = 32'h0; #0.5;
        check("R9", 4'b0000);

        // R1: reset clears a loaded configuration
        load_cfg(20'h0, 32'hFFFF_FFFF, 4'h0);
        #1; check("R1", 4'hF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        in_bus = 32'hFFFF_FFFF; #1;
        check("R1", 4'h0);

        done = 1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: expired, expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule